// File: doc/BRIEF.md
# Vector Single-Precision to Integer Converter

This block turns the single-precision lanes of a 128-bit vector operand into integers. It produces four signed 32-bit words, four unsigned 32-bit words, or two signed 64-bit values taken from either the lower or the upper pair of source lanes. Each conversion rounds with either a per-operation fixed mode or the dynamic mode supplied from the floating-point control register. Invalid and inexact flags are gathered over the lanes of one operation.

The unit is iterative: one lane is converted per cycle by a single shared lane converter. A state machine with the states IDLE, RUN and DONE sequences the work. The transition ACCEPT (IDLE to RUN) fires on `start` while idle. The transition STEP (RUN to RUN) writes one lane. The transition LAST (RUN to DONE) writes the final lane. The transition RETIRE (DONE to IDLE) follows after one cycle. `done` is high only in DONE. The result and flags stay put until the next accepted start.

Top module: `fcvt_vec_int`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `flag_invalid` and `flag_inexact` are all zero.
- R2: When `use_fixed` is 1, `fixed_rm` sets the rounding; otherwise `dyn_rm` does. The encoding is 0 = nearest-even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf.
- R3: Rounding follows the chosen mode. Nearest-even breaks ties to the even integer. Toward +inf and toward -inf round by value, not by magnitude.
- R4: `op_kind` 0 converts source lane i (bits 32i+31..32i) to a signed 32-bit word at the same bit position of `result`.
- R5: `op_kind` 1 converts each lane to an unsigned 32-bit word at the same position. With `use_fixed` 1 it always rounds toward zero, whatever `fixed_rm` holds. A negative value that rounds to 0 gives 0 with no invalid flag. A negative value that rounds to a nonzero integer gives 0 with invalid set. A value above 2^32-1 gives FFFFFFFF with invalid set.
- R6: `op_kind` 2 converts source lanes 0 and 1, and `op_kind` 3 converts source lanes 2 and 3. Each writes signed 64-bit results to `result` bits 63..0 and 127..64 in lane order.
- R7: A NaN lane gives 0 and sets invalid, with no inexact contribution.
- R8: A lane whose rounded value is outside the target range, or that is infinite, gives the largest or smallest value of the target type by sign and sets invalid.
- R9: `flag_inexact` is set when a lane discards a nonzero fraction and that lane is not invalid. Both flags are the OR over the lanes of the operation.
- R10: `start` is accepted only while `busy` is 0. `done` is a one-cycle pulse that rises N cycles after the accepting edge, where N is 4 for word forms and 2 for 64-bit forms. The result and flags are held from `done` until the next accepted start.
- R11: `start` raised while `busy` is 1 is ignored and does not change the running operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion, taken when idle |
| op_kind | input | 2 | 0 signed word, 1 unsigned word, 2 low pair to 64-bit, 3 high pair to 64-bit |
| use_fixed | input | 1 | Use the fixed rounding mode instead of the dynamic mode |
| fixed_rm | input | 2 | Fixed rounding mode carried by the operation |
| dyn_rm | input | 2 | Dynamic rounding mode from the control register |
| src | input | 128 | Four single-precision lanes |
| busy | output | 1 | An operation is in RUN or DONE |
| done | output | 1 | Result and flags are complete this cycle |
| result | output | 128 | Converted integers |
| flag_invalid | output | 1 | Some lane was NaN, infinite or out of range |
| flag_inexact | output | 1 | Some valid lane lost a fraction |

## Verification
The bench targets several corner cases. Ties at .5 under nearest-even are one: a design that rounds half away from zero returns 3 for 2.5. Negative values under the directed modes are another: confusing magnitude with value there rounds -2.5 toward -inf to -2. It also checks the exact boundaries 2^31, -2^31, 2^63 and -2^63, and unsigned negatives that round to zero, which a careless range check marks as invalid. NaN must give zero and not a saturated value. The high-pair form must read lanes 2 and 3. A start during busy must not corrupt the running result. Random lanes cover ordinary values against a model built on real arithmetic.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    typedef enum logic [1:0] {
        OPK_WORD_S = 2'd0,
        OPK_WORD_U = 2'd1,
        OPK_LONG_LO = 2'd2,
        OPK_LONG_HI = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsm_e;

    localparam int FP_W = 32;
    localparam int INT_W = 64;
endpackage

// File: rtl/fcvt_lane.sv
module fcvt_lane
    import fcvt_pkg::*;
(
    input  logic [FP_W-1:0]  fval,
    input  opk_e             kind,
    input  rnd_e             rnd,
    output logic [INT_W-1:0] ival,
    output logic             inv,
    output logic             inx
);
    localparam int FRAC_W = 23;
    localparam int WIDE_W = INT_W + FRAC_W + 1;

    logic              sgn;
    logic [7:0]        ex;
    logic [FRAC_W-1:0] fr;
    logic [WIDE_W-1:0] wide;
    logic [INT_W-1:0]  ipart;
    logic              rbit, sbit, huge, nan, inc, in_range;
    logic [INT_W:0]    mag;
    logic [INT_W-1:0]  sat;

    always_comb begin
        sgn   = fval[31];
        ex    = fval[30:23];
        fr    = fval[22:0];
        wide  = '0;
        ipart = '0;
        rbit  = 1'b0;
        sbit  = 1'b0;
        huge  = 1'b0;
        nan   = (ex == 8'hFF) && (fr != '0);
        if (ex >= 8'd191) begin
            huge = 1'b1;
        end else if (ex >= 8'd127) begin
            wide  = {{INT_W{1'b0}}, 1'b1, fr} << (ex - 8'd127);
            ipart = wide[WIDE_W-2:FRAC_W];
            rbit  = wide[FRAC_W-1];
            sbit  = |wide[FRAC_W-2:0];
        end else if (ex == 8'd126) begin
            rbit = 1'b1;
            sbit = |fr;
        end else begin
            sbit = (ex != 8'd0) || (fr != '0);
        end
    end

    always_comb begin
        unique case (rnd)
            RND_NEAR: inc = rbit & (sbit | ipart[0]);
            RND_ZERO: inc = 1'b0;
            RND_UP:   inc = ~sgn & (rbit | sbit);
            RND_DOWN: inc = sgn & (rbit | sbit);
            default:  inc = 1'b0;
        endcase
        mag = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
    end

    always_comb begin
        unique case (kind)
            OPK_WORD_S: begin
                in_range = sgn ? (mag <= 65'h0_8000_0000) : (mag <= 65'h0_7FFF_FFFF);
                sat      = sgn ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
            end
            OPK_WORD_U: begin
                in_range = sgn ? (mag == '0) : (mag <= 65'h0_FFFF_FFFF);
                sat      = sgn ? 64'h0 : 64'h0000_0000_FFFF_FFFF;
            end
            default: begin
                in_range = sgn ? (mag <= {2'b01, 63'h0}) : (mag[INT_W:INT_W-1] == 2'b00);
                sat      = sgn ? {1'b1, 63'h0} : {1'b0, {63{1'b1}}};
            end
        endcase
    end

    always_comb begin
        if (nan) begin
            ival = '0;
            inv  = 1'b1;
            inx  = 1'b0;
        end else if (huge || !in_range) begin
            ival = sat;
            inv  = 1'b1;
            inx  = 1'b0;
        end else begin
            ival = sgn ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
            inv  = 1'b0;
            inx  = rbit | sbit;
        end
    end
endmodule

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
    import fcvt_pkg::*;
#(
    parameter int NLANE = 4,
    localparam int IW = $clog2(NLANE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] last_idx,
    output logic          accept,
    output logic          lane_we,
    output logic [IW-1:0] idx,
    output logic          busy,
    output logic          done
);
    fsm_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_RUN;
            ST_RUN:  if (idx == last_idx) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE) idx <= '0;
            else if (st == ST_RUN) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        accept  = (st == ST_IDLE) && start;
        lane_we = (st == ST_RUN);
        busy    = (st != ST_IDLE);
        done    = (st == ST_DONE);
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: rtl/fcvt_vec_int.sv
module fcvt_vec_int
    import fcvt_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int NLANE = VEC_W / FP_W,
    localparam int IW = $clog2(NLANE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op_kind,
    input  logic             use_fixed,
    input  logic [1:0]       fixed_rm,
    input  logic [1:0]       dyn_rm,
    input  logic [VEC_W-1:0] src,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    logic [VEC_W-1:0] src_q;
    opk_e             kind_q;
    rnd_e             rnd_q;
    logic [VEC_W-1:0] res_q;
    logic             inv_q, inx_q;

    logic             accept, lane_we;
    logic [IW-1:0]    idx, last_idx, sel;
    logic [FP_W-1:0]  lanes [NLANE];
    logic [FP_W-1:0]  cur;
    logic [INT_W-1:0] l_val;
    logic             l_inv, l_inx;
    logic [IW+4:0]    woff;
    logic [IW+5:0]    loff;
    rnd_e             rnd_in;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = src_q[FP_W*g +: FP_W];
    end

    always_comb begin
        if (opk_e'(op_kind) == OPK_WORD_U && use_fixed) rnd_in = RND_ZERO;
        else if (use_fixed) rnd_in = rnd_e'(fixed_rm);
        else rnd_in = rnd_e'(dyn_rm);
        last_idx = (kind_q == OPK_WORD_S || kind_q == OPK_WORD_U) ?
                   IW'(NLANE - 1) : IW'(NLANE / 2 - 1);
        sel  = (kind_q == OPK_LONG_HI) ? idx + IW'(NLANE / 2) : idx;
        cur  = lanes[sel];
        woff = {idx, 5'b0};
        loff = {idx, 6'b0};
    end

    fcvt_ctrl #(.NLANE(NLANE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .last_idx(last_idx),
        .accept(accept), .lane_we(lane_we), .idx(idx), .busy(busy), .done(done)
    );

    fcvt_lane u_lane (
        .fval(cur), .kind(kind_q), .rnd(rnd_q),
        .ival(l_val), .inv(l_inv), .inx(l_inx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            kind_q <= OPK_WORD_S;
            rnd_q  <= RND_NEAR;
            res_q  <= '0;
            inv_q  <= 1'b0;
            inx_q  <= 1'b0;
        end else if (accept) begin
            src_q  <= src;
            kind_q <= opk_e'(op_kind);
            rnd_q  <= rnd_in;
            res_q  <= '0;
            inv_q  <= 1'b0;
            inx_q  <= 1'b0;
        end else if (lane_we) begin
            if (kind_q == OPK_WORD_S || kind_q == OPK_WORD_U)
                res_q[woff +: FP_W] <= l_val[FP_W-1:0];
            else
                res_q[loff +: INT_W] <= l_val;
            inv_q <= inv_q | l_inv;
            inx_q <= inx_q | l_inx;
        end
    end

    assign result       = res_q;
    assign flag_invalid = inv_q;
    assign flag_inexact = inx_q;

    a_r7_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we && cur[30:23] == 8'hFF && cur[22:0] != '0) |-> (l_val == '0 && l_inv && !l_inx));
    a_r9_inv_masks_inx: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we |-> !(l_inv && l_inx));
    a_r5_unsigned_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we && kind_q == OPK_WORD_U && cur[31]) |-> (l_val[FP_W-1:0] == '0));
    a_r11_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(src_q));
endmodule

// File: tb/fcvt_vec_int_tb.sv
module fcvt_vec_int_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op_kind = 2'd0;
    logic         use_fixed = 1'b0;
    logic [1:0]   fixed_rm = 2'd0;
    logic [1:0]   dyn_rm = 2'd0;
    logic [127:0] src = '0;
    logic         busy, done, flag_invalid, flag_inexact;
    logic [127:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fcvt_vec_int u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .use_fixed(use_fixed), .fixed_rm(fixed_rm), .dyn_rm(dyn_rm), .src(src),
        .busy(busy), .done(done), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    function automatic real pow2(input int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else for (int i = 0; i < -n; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic logic [63:0] sat_of(input logic [1:0] k, input logic s);
        if (k == 2'd0) return s ? 64'hFFFF_FFFF_8000_0000 : 64'h7FFF_FFFF;
        if (k == 2'd1) return s ? 64'h0 : 64'hFFFF_FFFF;
        return s ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
    endfunction

    // returns {invalid, inexact, value}
    function automatic logic [65:0] ref_lane(input logic [31:0] f, input logic [1:0] k,
                                             input logic [1:0] rm);
        logic s = f[31];
        int   e = int'(f[30:23]);
        int   m = int'(f[22:0]);
        real  a, sv, fl, r, mg;
        logic [63:0] q;
        logic bad;
        if (e == 255 && m != 0) return {2'b10, 64'h0};
        if (e == 255) return {2'b10, sat_of(k, s)};
        a  = (e == 0) ? m * pow2(-149) : (8388608.0 + m) * pow2(e - 150);
        if (a >= pow2(64)) return {2'b10, sat_of(k, s)};
        sv = s ? -a : a;
        fl = $floor(sv);
        case (rm)
            2'd1: r = s ? -$floor(a) : $floor(a);
            2'd2: r = $ceil(sv);
            2'd3: r = fl;
            default: begin
                if (sv - fl > 0.5) r = fl + 1.0;
                else if (sv - fl < 0.5) r = fl;
                else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
        endcase
        if (k == 2'd0) bad = (r > 2147483647.0) || (r < -2147483648.0);
        else if (k == 2'd1) bad = (r > 4294967295.0) || (r < 0.0);
        else bad = (r >= pow2(63)) || (r < -pow2(63));
        if (bad) return {2'b10, sat_of(k, s)};
        mg = (r < 0.0) ? -r : r;
        if (mg >= pow2(63)) q = 64'h8000_0000_0000_0000;
        else q = 64'(longint'(mg));
        if (r < 0.0) q = -q;
        return {1'b0, (r != sv), q};
    endfunction

    function automatic logic [129:0] ref_vec(input logic [127:0] v, input logic [1:0] k,
                                             input logic fx, input logic [1:0] frm,
                                             input logic [1:0] drm);
        logic [1:0]   rm = (k == 2'd1 && fx) ? 2'd1 : (fx ? frm : drm);
        logic [127:0] res = '0;
        logic         iv = 1'b0, ix = 1'b0;
        logic [65:0]  o;
        if (k <= 2'd1) begin
            for (int j = 0; j < 4; j++) begin
                o = ref_lane(v[32*j +: 32], k, rm);
                res[32*j +: 32] = o[31:0];
                iv |= o[65];
                ix |= o[64];
            end
        end else begin
            for (int j = 0; j < 2; j++) begin
                o = ref_lane(v[32*(j + ((k == 2'd3) ? 2 : 0)) +: 32], k, rm);
                res[64*j +: 64] = o[63:0];
                iv |= o[65];
                ix |= o[64];
            end
        end
        return {iv, ix, res};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] k, input logic fx,
                          input logic [1:0] frm, input logic [1:0] drm,
                          input logic [127:0] v);
        logic [129:0] e = ref_vec(v, k, fx, frm, drm);
        int cyc = 0;
        int n = (k <= 2'd1) ? 4 : 2;
        @(negedge clk);
        op_kind = k; use_fixed = fx; fixed_rm = frm; dyn_rm = drm; src = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " R10 latency"}, 128'(cyc), 128'(n));
        check({tag, " R4 R6 result"}, result, e[127:0]);
        check({tag, " R7 R8 invalid"}, 128'(flag_invalid), 128'(e[129]));
        check({tag, " R9 inexact"}, 128'(flag_inexact), 128'(e[128]));
        @(negedge clk);
        check({tag, " R10 pulse/hold"}, {126'(done), flag_invalid, flag_inexact} ^ 128'(0),
              {126'(0), e[129], e[128]});
    endtask

    function automatic logic [31:0] rnd_float();
        logic [31:0] f = $urandom;
        case ($urandom % 10)
            0: ;
            1: f = {f[31], 8'hFF, f[22:1], 1'b1};
            2: f = {f[31], 8'hFF, 23'h0};
            3: f = {f[31], 8'd127 + 8'($urandom % 8), f[22:20], 20'h0};
            default: f = {f[31], 8'd110 + 8'($urandom % 85), f[22:0]};
        endcase
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [129:0] ea;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {result[123:0], busy, done, flag_invalid, flag_inexact}, '0);
        rst_n = 1'b1;

        // R3 R2 ties and signs: 2.5, 3.5, -2.5, -1.5
        run_op("R3 nearest", 2'd0, 1'b1, 2'd0, 2'd3, {32'hBFC00000, 32'hC0200000, 32'h40600000, 32'h40200000});
        run_op("R3 zero", 2'd0, 1'b1, 2'd1, 2'd0, {32'hBFC00000, 32'hC0200000, 32'h40600000, 32'h40200000});
        run_op("R3 up", 2'd0, 1'b1, 2'd2, 2'd3, {32'hBFC00000, 32'hC0200000, 32'h40600000, 32'h40200000});
        run_op("R3 down", 2'd0, 1'b1, 2'd3, 2'd2, {32'hBFC00000, 32'hC0200000, 32'h40600000, 32'h40200000});
        run_op("R2 dynamic", 2'd0, 1'b0, 2'd2, 2'd3, {32'hBFC00000, 32'hC0200000, 32'h40600000, 32'h40200000});
        run_op("R9 exact", 2'd0, 1'b0, 2'd0, 2'd0, {32'h3F800000, 32'hBF800000, 32'h0, 32'h80000000});
        // R7 R8 NaN, infinities, 2^31 and -2^31 bounds
        run_op("R7 nan", 2'd0, 1'b1, 2'd1, 2'd0, {32'h3F800000, 32'h7FC00000, 32'h3F800000, 32'hFFC00001});
        run_op("R8 s32 bounds", 2'd0, 1'b1, 2'd1, 2'd0, {32'h7F800000, 32'hFF800000, 32'hCF000000, 32'h4F000000});
        // R5 unsigned: -0.5, -1.0, 2^32, 1.5, fixed up forced toward zero
        run_op("R5 unsigned", 2'd1, 1'b1, 2'd2, 2'd0, {32'hBF000000, 32'hBF800000, 32'h4F800000, 32'h3FC00000});
        run_op("R5 unsigned dyn", 2'd1, 1'b0, 2'd1, 2'd2, {32'hBF000000, 32'h3F000000, 32'h4F7FFFFF, 32'h3FC00000});
        // R6 low/high pairs with 2^63 and -2^63
        run_op("R6 low", 2'd2, 1'b1, 2'd1, 2'd0, {32'h40200000, 32'h3F800000, 32'hDF000000, 32'h5F000000});
        run_op("R6 high", 2'd3, 1'b1, 2'd0, 2'd0, {32'h40200000, 32'hDF000000, 32'h5F000000, 32'h7FC00000});

        // R11 start during busy is ignored
        ea = ref_vec({32'h40600000, 32'h3FC00000, 32'hC0200000, 32'h41200000}, 2'd0, 1'b1, 2'd0, 2'd0);
        @(negedge clk);
        op_kind = 2'd0; use_fixed = 1'b1; fixed_rm = 2'd0;
        src = {32'h40600000, 32'h3FC00000, 32'hC0200000, 32'h41200000};
        start = 1'b1;
        @(negedge clk);
        op_kind = 2'd3; src = '1; fixed_rm = 2'd2;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R11 busy start ignored", result, ea[127:0]);
        @(negedge clk);
        @(negedge clk);
        check("R11 no second op", 128'(busy), 128'(0));

        for (int t = 0; t < 120; t++) begin
            logic [1:0] rk = 2'($urandom % 4);
            run_op("R2 R3 R4 R5 R6 random", rk, 1'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4),
                   {rnd_float(), rnd_float(), rnd_float(), rnd_float()});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule